// File: doc/BRIEF.md
# Streaming Integer Square Root Unit

This block takes 32-bit unsigned integer operands from a streaming input and returns their square roots on a streaming output. The input side offers a data word with an "exists" flag, and the unit answers with a read acknowledge. The output side carries a 32-bit word with a write strobe, and the consumer can push back with a full flag. Each result is the 17-bit square root rounded to the nearest integer, zero-extended into the 32-bit output word.

Internally a non-pipelined datapath is used. It registers the operand, evaluates the root in one combinational pass, and registers the rounded result. A new-data strobe starts it and a one-cycle ready strobe ends it. A small controller lets only one operation be in flight at a time. It keeps the result until the consumer has room, and it applies a clock enable and a synchronous clear to all state.

Top module: `sqrt_stream_unit`

## Requirements
- R1: The result sits in `out_data[16:0]`. Bits `out_data[31:17]` are always zero and `out_ctrl` is always 0.
- R2: The result is the square root of the operand rounded to the nearest integer. Examples: 0→0, 2→1, 3→2, 15→4, 16928→130, 1048575→1024, 0xFFFE0001→65535, 0xFFFFFFFF→65536.
- R3: Small operands, including those below 0x4000 and the first operand after reset, give their correct nonzero root. Examples: 1→1, 4→2, 9→3, 16383→128.
- R4: `in_read` is high in exactly the cycles where `in_valid`, `ce` and idle all hold and `sclr` is low. The `in_data` of that cycle becomes the operand.
- R5: Suppose an operand is accepted in cycle n, `ce` stays high and `out_full` stays low. Then `out_write` is high in cycle n+2 only, and it carries that operand's result.
- R6: `out_write` is never high while `out_full` is high. The pending result stays stable on `out_data` and is written in the first cycle that `out_full` is low.
- R7: From the accept cycle through the cycle of its write, `in_read` stays low. A new operand can be accepted in the cycle after the write.
- R8: While `ce` is low, no operand is accepted, no result is written and all state is held. When `ce` returns high, the operation continues with its remaining latency.
- R9: A high `sclr` at a clock edge abandons any operation in flight, whatever `ce` is. No result is written for the abandoned operation, and the unit is idle afterwards.
- R10: `rst_n` is a synchronous active-low reset. After it, `out_write` is low and the unit is idle.
- R11: `in_data[31]` is the most significant operand bit, and no bit reversal is applied. Example: 0x00010000→256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ce | input | 1 | Clock enable; low freezes all state |
| sclr | input | 1 | Synchronous clear of the operation in flight |
| in_data | input | 32 | Operand word, unsigned, bit 31 most significant |
| in_valid | input | 1 | An operand word is present |
| in_read | output | 1 | Operand word taken this cycle |
| out_data | output | 32 | Result word, root in bits 16:0 |
| out_ctrl | output | 1 | Output tag bit, always 0 |
| out_write | output | 1 | Result word written this cycle |
| out_full | input | 1 | Consumer cannot take a word |

## Verification
The assertions assume that `out_full` and `in_valid` are driven to known levels in every cycle after reset. They also assume that `ce` and `sclr` change only between clock edges. The stimulus drives every input on the falling clock edge. It holds `in_valid` steady until `in_read` is seen, and it samples outputs half a cycle after each rising edge, so each input is stable across the edge that uses it. The latency property assumes nothing clears the unit in the cycle after acceptance. The tests that raise `ce` or `sclr` do so on purpose, and they are checked by directed cycle counts rather than by that property.

// File: rtl/sqrt_pkg.sv
// Package: shared widths for the streaming square root unit.
// Assumes operand widths are even so that bit pairs divide them cleanly.
package sqrt_pkg;
    localparam int SQ_OPND_W   = 32;                 // operand width
    localparam int SQ_STREAM_W = 32;                 // stream word width
    localparam int SQ_ROOT_W   = SQ_OPND_W / 2 + 1;  // rounded root width
endpackage

// File: rtl/sqrt_round_comb.sv
// Module: combinational integer square root with round-to-nearest.
// Uses a digit-by-digit restoring method, one operand bit pair per step.
// The floor root is incremented when the remainder exceeds it. An exact
// half cannot occur for integers, so this is round to nearest.
// Assumes OPND_W is even.
module sqrt_round_comb #(
    parameter int OPND_W = 32,
    localparam int HALF_W = OPND_W / 2,
    localparam int ROOT_W = HALF_W + 1
) (
    input  logic [OPND_W-1:0] opnd,
    output logic [ROOT_W-1:0] root
);
    localparam int REM_W = HALF_W + 4;

    logic [REM_W-1:0]  rem_v;
    logic [REM_W-1:0]  trial_v;
    logic [HALF_W-1:0] flr_v;

    // Purpose: iterate over bit pairs, then round the floor root.
    always_comb begin
        rem_v   = '0;
        flr_v   = '0;
        trial_v = '0;
        for (int i = HALF_W - 1; i >= 0; i--) begin
            rem_v   = {rem_v[REM_W-3:0], opnd[2*i +: 2]};
            trial_v = REM_W'({flr_v, 2'b01});
            if (rem_v >= trial_v) begin
                rem_v = rem_v - trial_v;
                flr_v = {flr_v[HALF_W-2:0], 1'b1};
            end else begin
                flr_v = {flr_v[HALF_W-2:0], 1'b0};
            end
        end
        root = ROOT_W'(flr_v) + ROOT_W'(rem_v > REM_W'(flr_v));
    end
endmodule

// File: rtl/sqrt_core.sv
// Module: registered, non-pipelined square root datapath.
// The operand register loads on nd. The result register loads one edge later,
// and rdy pulses for one cycle with the result. ce low freezes every register.
// sclr clears the valid flags whatever ce is. Assumes nd is not raised while
// an operation is still inside.
module sqrt_core #(
    parameter int OPND_W = 32,
    localparam int ROOT_W = OPND_W / 2 + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce,
    input  logic              sclr,
    input  logic              nd,
    input  logic [OPND_W-1:0] x_in,
    output logic [ROOT_W-1:0] x_out,
    output logic              rdy
);
    logic [OPND_W-1:0] opnd_q;
    logic              stage_v;
    logic [ROOT_W-1:0] root_c;

    sqrt_round_comb #(.OPND_W(OPND_W)) u_root (
        .opnd (opnd_q),
        .root (root_c)
    );

    // Purpose: input register and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opnd_q  <= '0;
            stage_v <= 1'b0;
        end else if (sclr) begin
            stage_v <= 1'b0;
        end else if (ce) begin
            stage_v <= nd;
            if (nd) opnd_q <= x_in;
        end
    end

    // Purpose: output register and the one-cycle ready strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_out <= '0;
            rdy   <= 1'b0;
        end else if (sclr) begin
            rdy <= 1'b0;
        end else if (ce) begin
            rdy <= stage_v;
            if (stage_v) x_out <= root_c;
        end
    end

    AST_CE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce && !sclr) |=> ($stable(rdy) && $stable(x_out))); // R8
    AST_SCLR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        sclr |=> !rdy); // R9
    AST_ROOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        rdy |-> (x_out <= ROOT_W'(1) << (OPND_W / 2))); // R2
endmodule

// File: rtl/sqrt_stream_ctrl.sv
// Module: stream-side control for one operation in flight.
// Acknowledges an input word only when idle. It holds a finished result
// until the consumer has room, and it tracks busy from accept to write.
// Assumes out_full is a level that means "do not write now".
module sqrt_stream_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic ce,
    input  logic sclr,
    input  logic in_valid,
    output logic in_read,
    input  logic out_full,
    output logic out_write,
    input  logic core_rdy,
    output logic core_nd
);
    logic busy_q;
    logic pend_q;

    // Purpose: accept and write decisions for the current cycle.
    always_comb begin
        in_read   = in_valid && ce && !sclr && !busy_q;
        core_nd   = in_read;
        out_write = ce && !sclr && !out_full && (core_rdy || pend_q);
    end

    // Purpose: busy spans accept to write; pend keeps a blocked result.
    always_ff @(posedge clk) begin
        if (!rst_n || sclr) begin
            busy_q <= 1'b0;
            pend_q <= 1'b0;
        end else if (ce) begin
            if (out_write) begin
                busy_q <= 1'b0;
                pend_q <= 1'b0;
            end else begin
                if (in_read)  busy_q <= 1'b1;
                if (core_rdy) pend_q <= 1'b1;
            end
        end
    end

    AST_NO_WRITE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        out_full |-> !out_write); // R6
    AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (core_rdy || pend_q) |-> !in_read); // R7
    AST_PEND_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        ((core_rdy || pend_q) && out_full && ce && !sclr) |=> pend_q); // R6
endmodule

// File: rtl/sqrt_stream_unit.sv
// Module: top of the streaming integer square root unit.
// Joins the stream control to the square root datapath and zero-extends
// the root into the stream word. Assumes STREAM_W >= ROOT_W.
module sqrt_stream_unit
    import sqrt_pkg::*;
#(
    parameter int OPND_W   = SQ_OPND_W,
    parameter int STREAM_W = SQ_STREAM_W,
    localparam int ROOT_W  = OPND_W / 2 + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ce,
    input  logic                sclr,
    input  logic [OPND_W-1:0]   in_data,
    input  logic                in_valid,
    output logic                in_read,
    output logic [STREAM_W-1:0] out_data,
    output logic                out_ctrl,
    output logic                out_write,
    input  logic                out_full
);
    logic              core_nd;
    logic              core_rdy;
    logic [ROOT_W-1:0] core_root;

    sqrt_stream_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce        (ce),
        .sclr      (sclr),
        .in_valid  (in_valid),
        .in_read   (in_read),
        .out_full  (out_full),
        .out_write (out_write),
        .core_rdy  (core_rdy),
        .core_nd   (core_nd)
    );

    sqrt_core #(.OPND_W(OPND_W)) u_core (
        .clk   (clk),
        .rst_n (rst_n),
        .ce    (ce),
        .sclr  (sclr),
        .nd    (core_nd),
        .x_in  (in_data),
        .x_out (core_root),
        .rdy   (core_rdy)
    );

    // Purpose: place the root in the low bits of the stream word.
    always_comb begin
        out_data = {{(STREAM_W - ROOT_W){1'b0}}, core_root};
        out_ctrl = 1'b0;
    end

    AST_LATENCY_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_read && !sclr) ##1 (ce && !sclr) |=> core_rdy); // R5
    AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (core_rdy && out_full && ce && !sclr) |=> $stable(out_data)); // R6
endmodule

// File: tb/sqrt_stream_unit_test.sv
module sqrt_stream_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce = 1'b1;
    logic        sclr = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_valid = 1'b0;
    logic        in_read;
    logic [31:0] out_data;
    logic        out_ctrl;
    logic        out_write;
    logic        out_full = 1'b0;

    int n_total = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    sqrt_stream_unit uut (
        .clk(clk), .rst_n(rst_n), .ce(ce), .sclr(sclr),
        .in_data(in_data), .in_valid(in_valid), .in_read(in_read),
        .out_data(out_data), .out_ctrl(out_ctrl),
        .out_write(out_write), .out_full(out_full)
    );

    always #5 clk = ~clk;

    localparam int NV = 14;
    localparam logic [31:0] V_IN [NV] = '{
        32'd0, 32'd1, 32'd2, 32'd3, 32'd4, 32'd9, 32'd15, 32'd16383,
        32'd16928, 32'h0001_0000, 32'd1048575, 32'd1048576,
        32'hFFFE_0001, 32'hFFFF_FFFF};
    localparam logic [16:0] V_EXP [NV] = '{
        17'd0, 17'd1, 17'd1, 17'd2, 17'd2, 17'd3, 17'd4, 17'd128,
        17'd130, 17'd256, 17'd1024, 17'd1024, 17'd65535, 17'd65536};

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_accept(input string req);
        for (int k = 0; k < 20 && !in_read; k++) begin
            @(negedge clk); #1;
        end
        chk(in_read, req, {31'd0, in_read}, 32'd1);
    endtask

    // One operation with the consumer ready: write expected in cycle n+2.
    task automatic run_op(input logic [31:0] x, input logic [16:0] exp, input string req);
        @(negedge clk);
        in_data = x; in_valid = 1'b1; #1;
        wait_accept("R4 accept");
        @(negedge clk); in_valid = 1'b0; #1;
        chk(!out_write, "R5 no early write", {31'd0, out_write}, 32'd0);
        @(negedge clk); #1;
        chk(out_write, "R5 write at n+2", {31'd0, out_write}, 32'd1);
        chk(out_data == {15'd0, exp}, req, out_data, {15'd0, exp});
        chk(!out_ctrl, "R1 ctrl zero", {31'd0, out_ctrl}, 32'd0);
        @(negedge clk); #1;
        chk(!out_write, "R5 single pulse", {31'd0, out_write}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_total++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin
        // R10: reset state
        repeat (3) @(negedge clk);
        #1;
        chk(!out_write, "R10 no write in reset", {31'd0, out_write}, 32'd0);
        @(negedge clk); rst_n = 1'b1; in_valid = 1'b1; in_data = 32'd4; #1;
        chk(in_read, "R10 idle after reset", {31'd0, in_read}, 32'd1);
        in_valid = 1'b0;

        // R3: first operand after reset is small
        run_op(32'd4, 17'd2, "R3 small first operand");

        // R2/R3/R11: vector table
        for (int v = 0; v < NV; v++)
            run_op(V_IN[v], V_EXP[v], "R2 R3 R11 table result");

        // R3: sweep of small operands against a real-valued model
        for (int x = 0; x < 64; x++)
            run_op(32'(x), 17'($rtoi($sqrt(real'(x)) + 0.5)), "R3 small sweep");

        // R6/R7: blocked output holds the result and stalls input
        out_full = 1'b1;
        @(negedge clk); in_data = 32'd9; in_valid = 1'b1; #1;
        wait_accept("R4 accept under full");
        @(negedge clk); in_data = 32'd100; #1;
        chk(!in_read, "R7 no accept in flight", {31'd0, in_read}, 32'd0);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); #1;
            chk(!out_write, "R6 no write while full", {31'd0, out_write}, 32'd0);
            chk(!in_read, "R7 no accept while held", {31'd0, in_read}, 32'd0);
            chk(out_data == 32'd3, "R6 held data", out_data, 32'd3);
        end
        @(negedge clk); out_full = 1'b0; #1;
        chk(out_write, "R6 write when room", {31'd0, out_write}, 32'd1);
        chk(out_data == 32'd3, "R6 written data", out_data, 32'd3);
        @(negedge clk); #1;
        chk(in_read, "R7 accept after write", {31'd0, in_read}, 32'd1);
        @(negedge clk); in_valid = 1'b0; #1;
        @(negedge clk); #1;
        chk(out_write && out_data == 32'd10, "R5 next result", out_data, 32'd10);

        // R8: clock enable low freezes an operation
        @(negedge clk); in_data = 32'd1048576; in_valid = 1'b1; #1;
        wait_accept("R4 accept before ce");
        @(negedge clk); in_valid = 1'b0; ce = 1'b0; #1;
        for (int k = 0; k < 2; k++) begin
            @(negedge clk); in_valid = 1'b1; in_data = 32'd4; #1;
            chk(!in_read, "R8 no accept when ce low", {31'd0, in_read}, 32'd0);
            chk(!out_write, "R8 no write when ce low", {31'd0, out_write}, 32'd0);
        end
        @(negedge clk); ce = 1'b1; in_valid = 1'b0; #1;
        chk(!out_write, "R8 remaining latency", {31'd0, out_write}, 32'd0);
        @(negedge clk); #1;
        chk(out_write && out_data == 32'd1024, "R8 resumed result", out_data, 32'd1024);

        // R9: synchronous clear abandons the operation
        @(negedge clk); in_data = 32'd49; in_valid = 1'b1; #1;
        wait_accept("R4 accept before clear");
        @(negedge clk); in_valid = 1'b0; sclr = 1'b1; #1;
        @(negedge clk); sclr = 1'b0; #1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); #1;
            chk(!out_write, "R9 no write after clear", {31'd0, out_write}, 32'd0);
        end
        run_op(32'd25, 17'd5, "R9 operation after clear");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule